// File: doc/BRIEF.md
# Multi-Format Serial Audio Transmitter

This block sends stereo samples to an external serial DAC over a three-wire link: bit clock, word select and data. It divides its master clock by four to form the bit clock. Each stereo frame is 64 bit-clock periods long, 32 per channel. The data bits are placed in one of four framings, chosen by a two-bit format code. The four framings differ in word-select polarity, in whether the first bit is delayed, in justification, and in resolution.

Samples arrive as parallel 20-bit left and right words through a valid/ready handshake. The handshake feeds a one-entry holding register. At each frame start the holding register is moved into the active sample, and the format code is sampled at the same moment. A frame cannot be torn by a late sample or by a format change. When no sample is pending, the frame carries silence.

Top module: `audio_serial_tx`

## Requirements
- R1: While running, the bit clock `sclkOut` is low for two master clocks and then high for two. A frame is 64 bit-clock periods long: slots 0 to 31 are the left channel and slots 32 to 63 the right.
- R2: While running, `lrclkOut` and `sdataOut` change only on the master clock edge at which `sclkOut` falls.
- R3: Format code 00: `lrclkOut` is low in the left half and high in the right half. Bits 19 down to 0 of the word occupy slots 1 to 20 of each half.
- R4: Format code 01: `lrclkOut` is high in the left half and low in the right half. Bits 19 down to 0 occupy slots 0 to 19 of each half.
- R5: Format code 10: word select is as in R4. Bits 19 down to 0 occupy slots 12 to 31 of each half, so bit 0 sits in the last slot before the word-select edge.
- R6: Format code 11: word select is as in R4. Bits 19 down to 4 of the word (16 bits) occupy slots 16 to 31 of each half.
- R7: Every slot not named in R3 to R6 for the active format drives `sdataOut` low.
- R8: `sampleReady` is high exactly when the one-entry holding register is empty. A word pair is taken on a clock with `sampleValid` and `sampleReady` high. The register empties, and `sampleReady` returns, on the frame-start edge that moves it into the active sample.
- R9: A frame that starts while the holding register is empty sends all-zero data in both halves. Word select keeps running.
- R10: `fmtSel` is sampled only on frame-start edges. A change in the middle of a frame alters neither the word select nor the data until the next frame.
- R11: While `rst` is high or `en` is low, `sclkOut`, `lrclkOut` and `sdataOut` are low. The first edge with `en` high presents slot 0 of a new frame with `sclkOut` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, four times the bit clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low holds the serial pins low |
| fmtSel | input | 2 | Framing code (00, 01, 10, 11) |
| sampleValid | input | 1 | Producer offers a stereo word pair |
| sampleReady | output | 1 | Holding register is free |
| sampleLeft | input | 20 | Left word, MSB at bit 19 |
| sampleRight | input | 20 | Right word, MSB at bit 19 |
| sclkOut | output | 1 | Serial bit clock |
| lrclkOut | output | 1 | Word-select clock |
| sdataOut | output | 1 | Serial data, MSB first |

## Verification
A slot counter that drifts by one misplaces the data window. In any framing, that shows as a wrong bit within one bit-clock period of the next nonzero sample bit. A divider phase error puts an edge of `sclkOut` off its two-clock rhythm at once. A stale active format or sample appears in the first slot of the next frame, and a lost holding flag appears at once on `sampleReady`. The bench compares every pin on every master clock against a behavioural frame model. It drives each framing, a mid-frame format change, a starved producer, and stop and restart through both enable and reset.

// File: rtl/sat_pkg.sv
`timescale 1ns/1ps
package sat_pkg;

  // slots per channel half; the frame holds two halves
  localparam int CH_SLOTS = 32;
  localparam int SLOT_W   = $clog2(2 * CH_SLOTS);

  typedef enum logic [1:0] {
    FMT_DELAYED  = 2'b00,
    FMT_LEFTJ    = 2'b01,
    FMT_RIGHTJ20 = 2'b10,
    FMT_RIGHTJ16 = 2'b11
  } txFmt_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic              idle;
    logic              slotStep;
    logic              frameLoad;
    logic [SLOT_W-1:0] nextSlot;
  } txStrobe_t;

endpackage

// File: rtl/sat_ctrl.sv
`timescale 1ns/1ps
module sat_ctrl
  import sat_pkg::*;
#(
  parameter int DIV_LOG2 = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      en,
  output txStrobe_t strobe,
  output logic      sclk,
  output logic      running
);

  localparam logic [DIV_LOG2-1:0] PH_LAST   = '1;
  localparam logic [SLOT_W-1:0]   SLOT_LAST = '1;

  logic [DIV_LOG2-1:0] phase;
  logic [DIV_LOG2-1:0] phaseNext;
  logic [SLOT_W-1:0]   slot;
  logic                stepNow;

  always_comb begin
    stepNow          = running && (phase == PH_LAST);
    phaseNext        = running ? phase + 1'b1 : '0;
    strobe.idle      = !en;
    strobe.slotStep  = en && (!running || stepNow);
    strobe.frameLoad = en && (!running || (stepNow && slot == SLOT_LAST));
    strobe.nextSlot  = running ? slot + 1'b1 : '0;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      running <= 1'b0;
      phase   <= '0;
      slot    <= '0;
      sclk    <= 1'b0;
    end else begin
      running <= 1'b1;
      phase   <= phaseNext;
      sclk    <= phaseNext[DIV_LOG2-1];
      if (stepNow) slot <= slot + 1'b1;
    end
  end

  AST_SCLK_HIGH_HOLD: assert property (@(posedge clk) disable iff (rst)
    ($rose(sclk) && en) |=> sclk);  // R1

  AST_SCLK_LOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    ($fell(sclk) && en && running) |=> !sclk);  // R1

endmodule

// File: rtl/sat_data.sv
`timescale 1ns/1ps
module sat_data
  import sat_pkg::*;
#(
  parameter int DATA_W  = 20,
  parameter int SHORT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        fmtSel,
  input  logic              sampleValid,
  output logic              sampleReady,
  input  logic [DATA_W-1:0] sampleLeft,
  input  logic [DATA_W-1:0] sampleRight,
  input  txStrobe_t         strobe,
  output logic              lrclk,
  output logic              sdata
);

  logic [DATA_W-1:0] holdLeft, holdRight;
  logic              holdFull;
  logic [DATA_W-1:0] actLeft, actRight;
  txFmt_e            fmtAct;

  logic [DATA_W-1:0] loadLeft, loadRight, useLeft, useRight;
  txFmt_e            useFmt;

  // word select level for a slot under a format
  function automatic logic slotLevel(input txFmt_e f, input logic [SLOT_W-1:0] s);
    logic leftHigh;
    leftHigh = (f != FMT_DELAYED);
    return s[SLOT_W-1] ? !leftHigh : leftHigh;
  endfunction

  // data bit for a slot under a format
  function automatic logic slotBit(input txFmt_e f, input logic [SLOT_W-1:0] s,
                                   input logic [DATA_W-1:0] l, input logic [DATA_W-1:0] r);
    logic [DATA_W-1:0] word;
    logic [DATA_W-1:0] shifted;
    int pos, first, span, idx;
    pos  = int'(s[SLOT_W-2:0]);
    word = s[SLOT_W-1] ? r : l;
    span = DATA_W;
    case (f)
      FMT_DELAYED:  first = 1;
      FMT_LEFTJ:    first = 0;
      FMT_RIGHTJ20: first = CH_SLOTS - DATA_W;
      default: begin
        first = CH_SLOTS - SHORT_W;
        span  = SHORT_W;
      end
    endcase
    if (pos >= first && pos < first + span) begin
      idx     = (DATA_W - 1) - (pos - first);
      shifted = word >> idx;
      return shifted[0];
    end
    return 1'b0;
  endfunction

  always_comb begin
    sampleReady = !holdFull;
    loadLeft    = holdFull ? holdLeft : '0;
    loadRight   = holdFull ? holdRight : '0;
    useLeft     = strobe.frameLoad ? loadLeft : actLeft;
    useRight    = strobe.frameLoad ? loadRight : actRight;
    useFmt      = strobe.frameLoad ? txFmt_e'(fmtSel) : fmtAct;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      holdLeft  <= '0;
      holdRight <= '0;
      holdFull  <= 1'b0;
      actLeft   <= '0;
      actRight  <= '0;
      fmtAct    <= FMT_DELAYED;
      lrclk     <= 1'b0;
      sdata     <= 1'b0;
    end else begin
      if (strobe.frameLoad && holdFull) begin
        holdFull <= 1'b0;
      end else if (sampleValid && !holdFull) begin
        holdLeft  <= sampleLeft;
        holdRight <= sampleRight;
        holdFull  <= 1'b1;
      end
      if (strobe.frameLoad) begin
        actLeft  <= loadLeft;
        actRight <= loadRight;
        fmtAct   <= useFmt;
      end
      if (strobe.idle) begin
        lrclk <= 1'b0;
        sdata <= 1'b0;
      end else if (strobe.slotStep) begin
        lrclk <= slotLevel(useFmt, strobe.nextSlot);
        sdata <= slotBit(useFmt, strobe.nextSlot, useLeft, useRight);
      end
    end
  end

  AST_TAKE_FILLS: assert property (@(posedge clk) disable iff (rst)
    (sampleValid && sampleReady) |=> !sampleReady);  // R8

  AST_LOAD_FREES: assert property (@(posedge clk) disable iff (rst)
    (strobe.frameLoad && !sampleReady) |=> sampleReady);  // R8

endmodule

// File: rtl/audio_serial_tx.sv
`timescale 1ns/1ps
module audio_serial_tx
  import sat_pkg::*;
#(
  parameter int DATA_W   = 20,
  parameter int SHORT_W  = 16,
  parameter int DIV_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [1:0]        fmtSel,
  input  logic              sampleValid,
  output logic              sampleReady,
  input  logic [DATA_W-1:0] sampleLeft,
  input  logic [DATA_W-1:0] sampleRight,
  output logic              sclkOut,
  output logic              lrclkOut,
  output logic              sdataOut
);

  txStrobe_t strobe;
  logic      running;

  sat_ctrl #(.DIV_LOG2(DIV_LOG2)) uCtrl (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .strobe  (strobe),
    .sclk    (sclkOut),
    .running (running)
  );

  sat_data #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) uData (
    .clk         (clk),
    .rst         (rst),
    .fmtSel      (fmtSel),
    .sampleValid (sampleValid),
    .sampleReady (sampleReady),
    .sampleLeft  (sampleLeft),
    .sampleRight (sampleRight),
    .strobe      (strobe),
    .lrclk       (lrclkOut),
    .sdata       (sdataOut)
  );

  AST_SDATA_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    ($past(running) && running && (sdataOut != $past(sdataOut))) |-> $fell(sclkOut));  // R2

  AST_LRCLK_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    ($past(running) && running && (lrclkOut != $past(lrclkOut))) |-> $fell(sclkOut));  // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!sclkOut && !lrclkOut && !sdataOut));  // R11

endmodule

// File: tb/tb_audio_serial_tx.sv
`timescale 1ns/1ps
module tb_audio_serial_tx;

  logic        clk = 1'b0;
  logic        rst, en, sampleValid, sampleReady;
  logic [1:0]  fmtSel;
  logic [19:0] sampleLeft, sampleRight;
  logic        sclkOut, lrclkOut, sdataOut;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  bit feedOn = 0;
  int wordCount = 0;

  always #10 clk = ~clk;

  audio_serial_tx dut (
    .clk(clk), .rst(rst), .en(en), .fmtSel(fmtSel),
    .sampleValid(sampleValid), .sampleReady(sampleReady),
    .sampleLeft(sampleLeft), .sampleRight(sampleRight),
    .sclkOut(sclkOut), .lrclkOut(lrclkOut), .sdataOut(sdataOut)
  );

  // behavioural frame model
  bit mRun, mFull, mActValid, lastAcc;
  int mT, mFmt, mHoldL, mHoldR, mActL, mActR;
  int eSclk, eLr, eSd;
  bit eInWin;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit acc;
    int slot, p, first, width, src, word;
    acc = sampleValid && !mFull && !rst;
    lastAcc = acc;
    if (rst) begin
      mRun = 0; mFull = 0; mT = 0;
    end else begin
      if (!en) begin
        mRun = 0; mT = 0;
      end else begin
        if (!mRun) begin mRun = 1; mT = 0; end
        else mT = mT + 1;
        if (mT % 256 == 0) begin
          if (mFull) begin
            mActL = mHoldL; mActR = mHoldR; mFull = 0; mActValid = 1;
          end else begin
            mActL = 0; mActR = 0; mActValid = 0;
          end
          mFmt = int'(fmtSel);
        end
      end
      if (acc) begin
        mHoldL = int'(sampleLeft); mHoldR = int'(sampleRight); mFull = 1;
      end
    end
    if (!mRun) begin
      eSclk = 0; eLr = 0; eSd = 0; eInWin = 0;
    end else begin
      slot  = (mT / 4) % 64;
      eSclk = ((mT % 4) >= 2) ? 1 : 0;
      p     = slot % 32;
      eLr   = (slot < 32) ? (mFmt != 0) : (mFmt == 0);
      word  = (slot < 32) ? mActL : mActR;
      case (mFmt)
        0: begin first = 1;  width = 20; src = word; end
        1: begin first = 0;  width = 20; src = word; end
        2: begin first = 12; width = 20; src = word; end
        default: begin first = 16; width = 16; src = word >> 4; end
      endcase
      eInWin = (p >= first) && (p < first + width);
      eSd = eInWin ? ((src >> (width - 1 - (p - first))) & 1) : 0;
    end
  end

  // compare every clock, away from the active edge, then feed the producer
  int  prevSclk = 0, prevLr = 0, prevSd = 0;
  bit  prevRun = 0;
  always @(negedge clk) begin
    string fTag, sdTag;
    if (!done) begin
      case (mFmt)
        0: fTag = "R3";
        1: fTag = "R4";
        2: fTag = "R5";
        default: fTag = "R6";
      endcase
      if (!mRun) sdTag = "R11";
      else if (!eInWin) sdTag = "R7";
      else if (!mActValid) sdTag = "R9";
      else if (int'(fmtSel) != mFmt) sdTag = "R10";
      else sdTag = fTag;
      chk(mRun ? "R1 sclk" : "R11 sclk", int'(sclkOut), eSclk);
      chk(mRun ? {fTag, " lrclk"} : "R11 lrclk", int'(lrclkOut), eLr);
      chk({sdTag, " sdata"}, int'(sdataOut), eSd);
      chk("R8 ready", int'(sampleReady), mFull ? 0 : 1);
      if (prevRun && mRun) begin
        total++;
        if ((int'(sdataOut) != prevSd || int'(lrclkOut) != prevLr) &&
            !(prevSclk == 1 && sclkOut == 1'b0)) begin
          bad++;
          $display("FAIL R2 edge actual=%0d%0d expected=10 at %0t", prevSclk, sclkOut, $time);
        end
      end
      prevSclk = int'(sclkOut); prevLr = int'(lrclkOut); prevSd = int'(sdataOut);
      prevRun  = mRun;
      if (sampleValid && lastAcc) sampleValid = 1'b0;
      if (!sampleValid && feedOn) begin
        wordCount++;
        case (wordCount % 5)
          0: begin sampleLeft = 20'hFFFFF; sampleRight = 20'h00001; end
          1: begin sampleLeft = 20'h80001; sampleRight = 20'hFFFFF; end
          2: begin sampleLeft = 20'hAAAAA; sampleRight = 20'h5555A; end
          default: begin sampleLeft = 20'($urandom); sampleRight = 20'($urandom); end
        endcase
        sampleValid = 1'b1;
      end
    end
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; en = 1'b0; fmtSel = 2'b00; sampleValid = 1'b0;
    sampleLeft = '0; sampleRight = '0;
    waitClk(5);
    rst = 1'b0;                    // R11 reset state checked above
    waitClk(3);
    feedOn = 1;
    waitClk(4);
    en = 1'b1;                     // R3 delayed framing
    waitClk(256 * 3 + 70);
    fmtSel = 2'b01;                // R10 mid-frame change, then R4
    waitClk(256 * 2);
    fmtSel = 2'b10;                // R5
    waitClk(256 * 2);
    fmtSel = 2'b11;                // R6
    waitClk(256 * 2);
    feedOn = 0;                    // R9 starved producer
    waitClk(256 * 3);
    feedOn = 1; fmtSel = 2'b00;
    waitClk(256 * 2 + 33);
    en = 1'b0;                     // R11 stop mid-frame
    waitClk(41);
    en = 1'b1; fmtSel = 2'b01;
    waitClk(256 * 2 + 10);
    rst = 1'b1;
    waitClk(4);
    rst = 1'b0; fmtSel = 2'b10;
    waitClk(256 * 2);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule